// File: doc/BRIEF.md
# Serial Audio Slot Transmit Channel

This block is one transmit channel of a serial audio link controller. Software writes one PCM sample at a time into a holding register. The sample may be 10, 16, 18 or 20 bits wide, in either byte order. On the write, the channel normalises the byte order and left-justifies the sample into a 20-bit slot word. A ready flag tells software when the holding register may be written again, and a maskable level interrupt follows that flag.

A separate frame sequencer pulses a one-cycle slot-start strobe at the start of each slot given to this channel. On that strobe, the held slot word moves into a 20-bit shift register. The word then leaves most significant bit first, one bit for each bit-clock enable. If software missed the slot, the channel sends twenty zero bits and raises a sticky underrun flag.

The channel is active only while both the controller-wide enable and the channel enable are set. While inactive, it discards its held sample, ignores writes, reports ready and holds the serial line low.

Top module: `audio_slot_tx`

## Requirements
- R1: The size field `size_sel` selects the sample width: 00 = 10 bits, 01 = 16 bits, 10 = 18 bits, 11 = 20 bits. The sample sits in the low bits of `wr_data` (bit 0 = sample LSB) and is placed in the slot with its MSB at slot bit 19. Slot bits below the sample are zero and word bits above it are ignored.
- R2: In the cycle after slot-start, `ser_out` shows slot bit 19. Each later `bit_ce` cycle advances it by one bit, toward bit 0, for 20 bits in all. A `bit_ce` in the same cycle as slot-start has no effect.
- R3: With `little_end` = 1, the bytes that carry the sample are reversed before R1 is applied. For the 10- and 16-bit sizes these are bytes 0 and 1 (`wr_data[15:0]`). For the 18- and 20-bit sizes they are bytes 0 to 2 (`wr_data[23:0]`), with byte 0 as the most significant.
- R4: Unless `glob_en` and `chan_en` are both 1, the channel behaves as follows: writes are ignored, a held sample is discarded, `tx_rdy` is 1, `ser_out` is 0, and slot-start loads nothing.
- R5: An accepted write (`wr_hold` = 1 while active) makes `tx_rdy` 0 from the next cycle on.
- R6: A slot-start while active moves the held sample into the shift register, and `tx_rdy` reads 1 from the next cycle on.
- R7: `irq` is 1 exactly when `irq_en` and `tx_rdy` are both 1. It is a level and stays high for as long as that holds.
- R8: A slot-start while active with nothing held sends 20 zero bits. `underrun` is set from the next cycle on and stays set until `underrun_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R9: If a write and a slot-start fall in the same cycle, the slot takes the previously held contents (zeros if none). The new sample is held, and `tx_rdy` is 0 afterwards.
- R10: After reset: `tx_rdy` = 1, `ser_out` = 0 and `underrun` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_en | input | 1 | Controller-wide enable |
| chan_en | input | 1 | Channel enable |
| size_sel | input | 2 | Sample width selector (R1 encoding) |
| little_end | input | 1 | 1 = little-endian written data |
| irq_en | input | 1 | Interrupt mask, 1 = unmasked |
| wr_hold | input | 1 | Holding register write strobe |
| wr_data | input | 24 | Written sample word |
| underrun_clr | input | 1 | Clears the underrun flag |
| slot_start | input | 1 | One-cycle start of this channel's slot |
| bit_ce | input | 1 | Bit-clock enable |
| ser_out | output | 1 | Serial slot data, MSB first |
| tx_rdy | output | 1 | Holding register empty |
| irq | output | 1 | Level interrupt |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The holding-register write and the slot-start transfer can land in the same cycle. One path sets the ready flag and the other clears it. The bench provokes this by raising `wr_hold` and `slot_start` on the same edge, once with a sample already held and once with the register empty. It judges the result by checking that the serial bits of that slot carry the old sample (or zeros with underrun raised) and that the next slot carries the new sample while `tx_rdy` stays low in between.

// File: rtl/audio_tx_pkg.sv
// Package: shared types and helpers for the slot transmit channel.
// Assumes a fixed slot width of 20 bits and byte-wide lanes.
package audio_tx_pkg;
    localparam int SLOT_W = 20;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_10 = 2'b00,
        SZ_16 = 2'b01,
        SZ_18 = 2'b10,
        SZ_20 = 2'b11
    } samp_size_e;

    // Sample width in bits for a size code.
    function automatic int samp_bits(input samp_size_e sz);
        case (sz)
            SZ_10:   return 10;
            SZ_16:   return 16;
            SZ_18:   return 18;
            default: return 20;
        endcase
    endfunction

    // Number of byte lanes holding valid sample bits.
    function automatic int samp_lanes(input samp_size_e sz);
        return (samp_bits(sz) + LANE_W - 1) / LANE_W;
    endfunction
endpackage

// File: rtl/sample_packer.sv
// Sample packer: turns a written word into a 20-bit slot word.
// Reverses the valid byte lanes in little-endian mode, masks the sample
// to its width and left-justifies it with zero fill. Purely combinational.
// Assumes WORD_W >= SLOT_W and WORD_W covers three byte lanes.
module sample_packer
    import audio_tx_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOT_W_P = SLOT_W
) (
    input  logic [WORD_W-1:0]   word_in,
    input  logic [1:0]          size_code,
    input  logic                little_end,
    output logic [SLOT_W_P-1:0] slot_word
);
    localparam int N_LANES = WORD_W / LANE_W;

    logic [WORD_W-1:0] ordered;
    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] justified;
    int                nbits;
    int                nlanes;

    // Normalise byte order over the lanes the sample occupies.
    always_comb begin
        nbits  = samp_bits(samp_size_e'(size_code));
        nlanes = samp_lanes(samp_size_e'(size_code));
        ordered = word_in;
        if (little_end) begin
            ordered = '0;
            for (int i = 0; i < N_LANES; i++) begin
                if (i < nlanes)
                    ordered[i*LANE_W +: LANE_W] = word_in[(nlanes-1-i)*LANE_W +: LANE_W];
            end
        end
    end

    // Keep only the sample bits and move its MSB to the slot MSB.
    always_comb begin
        masked    = ordered & ((WORD_W'(1) << nbits) - WORD_W'(1));
        justified = masked << (SLOT_W_P - nbits);
        slot_word = justified[SLOT_W_P-1:0];
    end
endmodule

// File: rtl/hold_ctrl.sv
// Holding register control: stores one packed slot word, tracks the
// full/empty state behind the ready flag and keeps the sticky underrun flag.
// Assumes slot_start is a single-cycle strobe from the frame sequencer.
module hold_ctrl #(
    parameter int SLOT_W_P = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                wr_en,
    input  logic [SLOT_W_P-1:0] wr_slot,
    input  logic                slot_start,
    input  logic                urun_clr,
    output logic                full_q,
    output logic                urun_q,
    output logic                load,
    output logic [SLOT_W_P-1:0] load_data
);
    logic [SLOT_W_P-1:0] hold_q;
    logic                wr_ok;

    assign wr_ok     = active && wr_en;
    assign load      = active && slot_start;
    assign load_data = full_q ? hold_q : '0;

    // Holding register and its full flag; a write beats the slot hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (!active) begin
            full_q <= 1'b0;
        end else begin
            if (slot_start)
                full_q <= 1'b0;
            if (wr_ok) begin
                hold_q <= wr_slot;
                full_q <= 1'b1;
            end
        end
    end

    // Sticky underrun: set on an empty slot start, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            urun_q <= 1'b0;
        else if (load && !full_q)
            urun_q <= 1'b1;
        else if (urun_clr)
            urun_q <= 1'b0;
    end

    a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> full_q);
    a_r6_start_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_ok) |=> !full_q);
    a_r8_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !full_q) |=> urun_q);
    a_r9_collision_holds_new: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr_ok) |=> (full_q && hold_q == $past(wr_slot)));
    a_r4_inactive_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !full_q);
endmodule

// File: rtl/slot_shifter.sv
// Slot shifter: 20-bit shift register loaded at slot start and shifted
// MSB first on each bit-clock enable, at most SLOT_W_P shifts per slot.
// Assumes load and bit_ce come from the same clock domain.
module slot_shifter #(
    parameter int SLOT_W_P = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                load,
    input  logic [SLOT_W_P-1:0] load_data,
    input  logic                bit_ce,
    output logic                ser_out
);
    localparam int CNT_W = $clog2(SLOT_W_P + 1);

    logic [SLOT_W_P-1:0] shreg;
    logic [CNT_W-1:0]    bits_left;

    assign ser_out = shreg[SLOT_W_P-1];

    // Load on slot start, otherwise shift while bits remain.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (load) begin
            shreg     <= load_data;
            bits_left <= CNT_W'(SLOT_W_P);
        end else if (bit_ce && bits_left != '0) begin
            shreg     <= {shreg[SLOT_W_P-2:0], 1'b0};
            bits_left <= bits_left - CNT_W'(1);
        end
    end

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bits_left <= CNT_W'(SLOT_W_P));
    a_r2_next_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && bit_ce && bits_left != '0) |=> (ser_out == $past(shreg[SLOT_W_P-2])));
    a_r2_load_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (active && load) |=> (ser_out == $past(load_data[SLOT_W_P-1])));
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !ser_out);
endmodule

// File: rtl/audio_slot_tx.sv
// Top of one transmit channel of the serial audio link.
// Packs written samples, hands them to the slot shifter on slot start,
// and drives the ready flag, level interrupt and underrun flag.
// Assumes the frame sequencer supplies slot_start and bit_ce.
module audio_slot_tx
    import audio_tx_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic              chan_en,
    input  logic [1:0]        size_sel,
    input  logic              little_end,
    input  logic              irq_en,
    input  logic              wr_hold,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              underrun_clr,
    input  logic              slot_start,
    input  logic              bit_ce,
    output logic              ser_out,
    output logic              tx_rdy,
    output logic              irq,
    output logic              underrun
);
    logic              active;
    logic [SLOT_W-1:0] packed_slot;
    logic              full;
    logic              do_load;
    logic [SLOT_W-1:0] load_word;

    assign active = glob_en && chan_en;

    sample_packer #(.WORD_W(WORD_W), .SLOT_W_P(SLOT_W)) u_pack (
        .word_in    (wr_data),
        .size_code  (size_sel),
        .little_end (little_end),
        .slot_word  (packed_slot)
    );

    hold_ctrl #(.SLOT_W_P(SLOT_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .wr_en      (wr_hold),
        .wr_slot    (packed_slot),
        .slot_start (slot_start),
        .urun_clr   (underrun_clr),
        .full_q     (full),
        .urun_q     (underrun),
        .load       (do_load),
        .load_data  (load_word)
    );

    slot_shifter #(.SLOT_W_P(SLOT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .load       (do_load),
        .load_data  (load_word),
        .bit_ce     (bit_ce),
        .ser_out    (ser_out)
    );

    // Ready flag and level interrupt from the holding register state.
    always_comb begin
        tx_rdy = !full;
        irq    = irq_en && tx_rdy;
    end

    a_r7_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tx_rdy);
    a_r5_rdy_drops_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_hold) |=> !tx_rdy);
    a_r6_rdy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (active && slot_start && !wr_hold) |=> tx_rdy);
endmodule

// File: tb/sim_audio_slot_tx.sv
module sim_audio_slot_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glob_en = 1'b0, chan_en = 1'b0;
    logic [1:0]  size_sel = 2'b11;
    logic        little_end = 1'b0, irq_en = 1'b1;
    logic        wr_hold = 1'b0;
    logic [23:0] wr_data = '0;
    logic        underrun_clr = 1'b0, slot_start = 1'b0, bit_ce = 1'b0;
    logic        ser_out, tx_rdy, irq, underrun;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    audio_slot_tx u0 (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .chan_en(chan_en),
        .size_sel(size_sel), .little_end(little_end), .irq_en(irq_en),
        .wr_hold(wr_hold), .wr_data(wr_data), .underrun_clr(underrun_clr),
        .slot_start(slot_start), .bit_ce(bit_ce), .ser_out(ser_out),
        .tx_rdy(tx_rdy), .irq(irq), .underrun(underrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected slot word, built bit by bit from the requirements.
    function automatic logic [19:0] ref_slot(input logic [23:0] w, input logic [1:0] sz, input logic le);
        int          nb;
        logic [23:0] n;
        logic [19:0] s;
        nb = (sz == 2'b00) ? 10 : (sz == 2'b01) ? 16 : (sz == 2'b10) ? 18 : 20;
        n = w;
        if (le) n = (nb <= 16) ? {8'h00, w[7:0], w[15:8]} : {w[7:0], w[15:8], w[23:16]};
        s = '0;
        for (int b = 0; b < nb; b++) s[19-b] = n[nb-1-b];
        return s;
    endfunction

    task automatic write_word(input logic [23:0] w);
        wr_data = w; wr_hold = 1'b1;
        @(negedge clk); wr_hold = 1'b0;
    endtask

    // Pulse slot start (optionally with a write) and collect 20 bits.
    task automatic run_slot(input logic with_wr, input logic [23:0] w, output logic [19:0] got);
        slot_start = 1'b1;
        if (with_wr) begin wr_data = w; wr_hold = 1'b1; end
        @(negedge clk);
        slot_start = 1'b0; wr_hold = 1'b0;
        for (int i = 0; i < 20; i++) begin
            got[19-i] = ser_out;
            bit_ce = 1'b1;
            @(negedge clk);
            bit_ce = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R10 tx_rdy", 32'(tx_rdy), 1);
        check("R10 ser_out", 32'(ser_out), 0);
        check("R10 underrun", 32'(underrun), 0);
        check("R7 irq after reset", 32'(irq), 1);
    endtask

    task automatic t_format(input logic [1:0] sz, input logic le, input logic [23:0] w, input string tag);
        logic [19:0] got;
        size_sel = sz; little_end = le;
        write_word(w);
        check({"R5 rdy low ", tag}, 32'(tx_rdy), 0);
        check({"R7 irq low ", tag}, 32'(irq), 0);
        run_slot(1'b0, '0, got);
        check({"R1 R2 R3 slot ", tag}, 32'(got), 32'(ref_slot(w, sz, le)));
        check({"R6 rdy back ", tag}, 32'(tx_rdy), 1);
        check({"R8 no underrun ", tag}, 32'(underrun), 0);
    endtask

    task automatic t_underrun;
        logic [19:0] got;
        run_slot(1'b0, '0, got);
        check("R8 zero slot", 32'(got), 0);
        check("R8 underrun set", 32'(underrun), 1);
        check("R8 rdy stays", 32'(tx_rdy), 1);
        underrun_clr = 1'b1; @(negedge clk); underrun_clr = 1'b0;
        check("R8 underrun cleared", 32'(underrun), 0);
    endtask

    task automatic t_collision;
        logic [19:0] got;
        size_sel = 2'b11; little_end = 1'b0;
        write_word(24'h0ABCDE);
        run_slot(1'b1, 24'h012345, got);
        check("R9 old sample sent", 32'(got), 32'h0ABCDE);
        check("R9 new held rdy low", 32'(tx_rdy), 0);
        run_slot(1'b0, '0, got);
        check("R9 new sample next slot", 32'(got), 32'h12345);
        run_slot(1'b1, 24'h054321, got);
        check("R9 empty collision zeros", 32'(got), 0);
        check("R9 empty collision underrun", 32'(underrun), 1);
        check("R9 empty collision rdy low", 32'(tx_rdy), 0);
        underrun_clr = 1'b1; @(negedge clk); underrun_clr = 1'b0;
        run_slot(1'b0, '0, got);
        check("R9 late sample next slot", 32'(got), 32'h54321);
    endtask

    task automatic t_disable;
        logic [19:0] got;
        write_word(24'h0FFFFF);
        chan_en = 1'b0; @(negedge clk);
        check("R4 held discarded rdy", 32'(tx_rdy), 1);
        write_word(24'h0FFFFF);
        check("R4 write ignored", 32'(tx_rdy), 1);
        run_slot(1'b0, '0, got);
        check("R4 line low", 32'(got), 0);
        check("R4 no underrun when off", 32'(underrun), 0);
        chan_en = 1'b1; glob_en = 1'b0;
        write_word(24'h0FFFFF);
        check("R4 global off ignores write", 32'(tx_rdy), 1);
        glob_en = 1'b1; @(negedge clk);
        run_slot(1'b0, '0, got);
        check("R4 nothing held after re-enable", 32'(got), 0);
        underrun_clr = 1'b1; @(negedge clk); underrun_clr = 1'b0;
    endtask

    task automatic t_mask;
        irq_en = 1'b0; @(negedge clk);
        check("R7 masked irq", 32'(irq), 0);
        irq_en = 1'b1; @(negedge clk);
        check("R7 unmasked irq level", 32'(irq), 1);
        @(negedge clk);
        check("R7 irq stays high", 32'(irq), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        glob_en = 1'b1; chan_en = 1'b1;
        @(negedge clk);
        t_format(2'b11, 1'b0, 24'hA5C3F1, "20b big");
        t_format(2'b01, 1'b0, 24'hFF9A3C, "16b big");
        t_format(2'b00, 1'b0, 24'hFFF2B7, "10b big");
        t_format(2'b00, 1'b1, 24'h00B702, "10b little");
        t_format(2'b01, 1'b1, 24'h003412, "16b little");
        t_format(2'b10, 1'b1, 24'h563412, "18b little");
        t_format(2'b11, 1'b1, 24'h0A3B5C, "20b little");
        t_format(2'b10, 1'b0, 24'hC2D5E7, "18b big");
        t_underrun();
        t_collision();
        t_disable();
        t_mask();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule